// File: doc/BRIEF.md
# Multi-mode 16-bit timer counter

This block is one 16-bit timer channel. It counts up or down. In free-running mode it wraps across the full 16-bit range. In interval mode it restarts at a programmed limit. The counter advances on ticks of either the system clock or an external input. The external input is synchronised and edge-detected in the system clock domain, and an optional power-of-two prescaler divides the ticks.

Three match registers are compared with the count. Match 0 also drives a waveform output that flips on match and returns to idle on each wrap. Events are latched in sticky status flags. A level interrupt is raised for every flag that has its enable set.

Software reaches the registers through a simple synchronous bus. It has an address, a write strobe with write data, a read strobe and combinational read data. Register addresses are: 0 clock setup, 1 count control, 2 counter value, 3 interval limit, 4/5/6 match 0/1/2, 7 status, 8 interrupt enable.

Top module: `tmr_channel`

## Requirements
- R1: Out of reset, count control (address 1) reads 0x21 (bit 0 = counter disabled, bit 5 = waveform off). Clock setup reads 0, the counter reads 0, and `wave_o` and `irq_o` are 0.
- R2: The counter value at address 2 is read-only, and a write to address 2 leaves it unchanged.
- R3: With count control bits 2:1 = 00 (up, free-running) and the system clock selected, the counter advances by one on every clock edge after a restart. Going from 0xFFFF to 0 sets status bit 4.
- R4: With count control bit 1 = 1 (interval mode), counting up runs from 0 to the interval value at address 3 and then returns to 0, setting status bit 0.
- R5: With count control bit 2 = 1 the counter counts down. From 0 it goes to 0xFFFF in free-running mode or to the interval value in interval mode. This sets status bit 4 or bit 0 respectively.
- R6: Clock setup bit 0 enables the prescaler and bits 4:1 hold N. When it is enabled, the counter advances once per 2^(N+1) selected ticks; when it is disabled, it advances on every tick.
- R7: Clock setup bit 5 = 1 selects the synchronised `ext_clk` input as the tick source. Bit 6 = 0 counts its rising edges, and bit 6 = 1 counts its falling edges.
- R8: While count control bit 0 is 1, the counter holds its value.
- R9: Writing count control with bit 4 = 1 zeroes the counter and the prescaler on the next edge. Bit 4 reads back as 1 until that edge and as 0 afterwards.
- R10: A match event occurs when the counter steps onto the value in match register i (addresses 4 to 6). It sets status bit i+1 only when count control bit 3 is 1.
- R11: Status bits at address 7 are sticky. A read with `bus_re` at address 7 clears them, but an event in the same cycle stays set. Bit 5 always reads 0.
- R12: `irq_o` is 1 exactly when some status bit and the same bit of the enable register at address 8 are both 1.
- R13: With count control bit 5 = 0, `wave_o` is driven from an internal active flag. The flag is set by a match 0 event and cleared by a wrap or a restart. With bit 6 = 0, `wave_o` is 1 when the flag is clear and 0 when it is set; bit 6 = 1 inverts this. With bit 5 = 1, `wave_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External tick input, asynchronous |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe, clears status on address 7 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| wave_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take it that a restart is never written on the same edge that the pending restart takes effect. They also take it that the bus strobes are known after reset. The rules on advancing and holding assume that `ext_clk` stays at each level for several system clocks, so that no edge is lost in the synchroniser. The stimulus holds each external level for four cycles and changes it at the falling clock edge. It writes control registers only at falling edges, and it disables the counter before reading status, so no event lands during a check.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NMATCH = 3;
    localparam int STW    = 6;
    localparam int ADR_CLK  = 0;
    localparam int ADR_CNT  = 1;
    localparam int ADR_VAL  = 2;
    localparam int ADR_IVL  = 3;
    localparam int ADR_MT0  = 4;
    localparam int ADR_STAT = 7;
    localparam int ADR_IEN  = 8;
    // count control bit positions
    localparam int CC_DIS  = 0;
    localparam int CC_IVL  = 1;
    localparam int CC_DOWN = 2;
    localparam int CC_MEN  = 3;
    localparam int CC_RST  = 4;
    localparam int CC_WOFF = 5;
    localparam int CC_POL  = 6;
    localparam logic [6:0] CNT_RESET = 7'h21;
    // status bit positions
    localparam int ST_IVL = 0;
    localparam int ST_OVF = 4;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int SYNC = 2,
    parameter int PSW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ext_in,
    input  logic           src_ext,
    input  logic           fall_sel,
    input  logic           pre_en,
    input  logic [PSW-1:0] pre_sel,
    input  logic           restart,
    output logic           adv_o
);
    localparam int DIVW = (1 << PSW) + 1;

    typedef struct packed {
        logic [SYNC:0]     sync;
        logic [DIVW-1:0]   div;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic src_tick, ext_rise, ext_fall;
    logic [DIVW-1:0] limit;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC-1:0], ext_in};
        ext_rise  = st_q.sync[SYNC-1] & ~st_q.sync[SYNC];
        ext_fall  = ~st_q.sync[SYNC-1] & st_q.sync[SYNC];
        src_tick  = src_ext ? (fall_sel ? ext_fall : ext_rise) : 1'b1;
        limit     = (DIVW'(1) << ({1'b0, pre_sel} + (PSW+1)'(1))) - DIVW'(1);
        adv_o     = 1'b0;
        if (restart) begin
            st_d.div = '0;
        end else if (src_tick) begin
            if (!pre_en) begin
                adv_o = 1'b1;
            end else if (st_q.div >= limit) begin
                adv_o    = 1'b1;
                st_d.div = '0;
            end else begin
                st_d.div = st_q.div + DIVW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    adv_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |-> src_tick);
    // R9
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.div == '0));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          hold,
    input  logic          restart,
    input  logic          ivl_mode,
    input  logic          down,
    input  logic [CW-1:0] ival,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nxt,
    output logic          step_o,
    output logic          wrap_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic at_end;

    always_comb begin
        step_o = adv & ~hold & ~restart;
        if (down)          at_end = (cnt_q == '0);
        else if (ivl_mode) at_end = (cnt_q == ival);
        else               at_end = (cnt_q == '1);
        if (!down)         cnt_nxt = at_end ? '0 : cnt_q + CW'(1);
        else if (at_end)   cnt_nxt = ivl_mode ? ival : '1;
        else               cnt_nxt = cnt_q - CW'(1);
        wrap_o = step_o & at_end;
        if (restart)       cnt_d = '0;
        else if (step_o)   cnt_d = cnt_nxt;
        else               cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !restart) |=> $stable(cnt_q));
    // R9
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    // R4
    ivl_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && ivl_mode && !down && cnt_q == ival) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_match_wave.sv
module tmr_match_wave #(
    parameter int CW = 16,
    parameter int NM = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step,
    input  logic [CW-1:0]          cnt_nxt,
    input  logic [NM-1:0][CW-1:0]  mval,
    input  logic                   wrap,
    input  logic                   restart,
    input  logic                   pol,
    input  logic                   wave_off,
    output logic [NM-1:0]          hit_o,
    output logic                   wave_o
);
    logic act_d, act_q;

    for (genvar g = 0; g < NM; g++) begin : g_cmp
        assign hit_o[g] = step & (cnt_nxt == mval[g]);
    end

    always_comb begin
        act_d = act_q;
        if (restart)       act_d = 1'b0;
        else if (hit_o[0]) act_d = 1'b1;
        else if (wrap)     act_d = 1'b0;
        wave_o = wave_off ? 1'b0 : ~(act_q ^ pol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end

    // R13
    act_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o[0] |=> act_q);
    // R10
    hit_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_o) |-> step);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW   = 16,
    parameter int AW   = 4,
    parameter int PSW  = 4,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_clk,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic          wave_o,
    output logic          irq_o
);
    localparam int NM = NMATCH;

    typedef struct packed {
        logic [6:0]               clk_cfg;
        logic [6:0]               cnt_cfg;
        logic                     restart;
        logic [CW-1:0]            ival;
        logic [NM-1:0][CW-1:0]    mval;
        logic [STW-1:0]           stat;
        logic [STW-1:0]           ien;
    } regs_t;

    regs_t r_d, r_q;
    logic adv, step, wrap;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [NM-1:0] hit;
    logic [STW-1:0] st_set;
    logic st_clr;

    tmr_tick_gen #(.SYNC(SYNC), .PSW(PSW)) u_tick (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_clk),
        .src_ext(r_q.clk_cfg[5]), .fall_sel(r_q.clk_cfg[6]),
        .pre_en(r_q.clk_cfg[0]), .pre_sel(r_q.clk_cfg[PSW:1]),
        .restart(r_q.restart), .adv_o(adv)
    );

    tmr_count_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .adv(adv), .hold(r_q.cnt_cfg[CC_DIS]),
        .restart(r_q.restart), .ivl_mode(r_q.cnt_cfg[CC_IVL]),
        .down(r_q.cnt_cfg[CC_DOWN]), .ival(r_q.ival),
        .cnt_o(cnt), .cnt_nxt(cnt_nxt), .step_o(step), .wrap_o(wrap)
    );

    tmr_match_wave #(.CW(CW), .NM(NM)) u_wave (
        .clk(clk), .rst_n(rst_n), .step(step), .cnt_nxt(cnt_nxt),
        .mval(r_q.mval), .wrap(wrap), .restart(r_q.restart),
        .pol(r_q.cnt_cfg[CC_POL]), .wave_off(r_q.cnt_cfg[CC_WOFF]),
        .hit_o(hit), .wave_o(wave_o)
    );

    always_comb begin
        r_d         = r_q;
        r_d.restart = 1'b0;
        if (bus_we) begin
            if (bus_addr == AW'(ADR_CLK)) r_d.clk_cfg = bus_wdata[6:0];
            if (bus_addr == AW'(ADR_CNT)) begin
                r_d.cnt_cfg         = bus_wdata[6:0];
                r_d.cnt_cfg[CC_RST] = 1'b0;
                r_d.restart         = bus_wdata[CC_RST];
            end
            if (bus_addr == AW'(ADR_IVL)) r_d.ival = bus_wdata;
            for (int i = 0; i < NM; i++)
                if (bus_addr == AW'(ADR_MT0 + i)) r_d.mval[i] = bus_wdata;
            if (bus_addr == AW'(ADR_IEN)) r_d.ien = bus_wdata[STW-1:0];
        end
        st_set = '0;
        st_set[ST_IVL]  = wrap & r_q.cnt_cfg[CC_IVL];
        st_set[ST_OVF]  = wrap & ~r_q.cnt_cfg[CC_IVL];
        st_set[NM:1]    = hit & {NM{r_q.cnt_cfg[CC_MEN]}};
        st_clr   = bus_re & (bus_addr == AW'(ADR_STAT));
        r_d.stat = (st_clr ? '0 : r_q.stat) | st_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.cnt_cfg <= CNT_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADR_CLK))  bus_rdata = CW'(r_q.clk_cfg);
        if (bus_addr == AW'(ADR_CNT))
            bus_rdata = CW'({r_q.cnt_cfg[6:5], r_q.restart, r_q.cnt_cfg[3:0]});
        if (bus_addr == AW'(ADR_VAL))  bus_rdata = cnt;
        if (bus_addr == AW'(ADR_IVL))  bus_rdata = r_q.ival;
        for (int i = 0; i < NM; i++)
            if (bus_addr == AW'(ADR_MT0 + i)) bus_rdata = r_q.mval[i];
        if (bus_addr == AW'(ADR_STAT)) bus_rdata = CW'(r_q.stat);
        if (bus_addr == AW'(ADR_IEN))  bus_rdata = CW'(r_q.ien);
    end

    assign irq_o = |(r_q.stat & r_q.ien);

    // R9
    restart_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.restart && !(bus_we && bus_addr == AW'(ADR_CNT) && bus_wdata[CC_RST]))
        |=> !r_q.restart);
    // R11
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_re && bus_addr == AW'(ADR_STAT))
        |=> ((r_q.stat & $past(r_q.stat)) == $past(r_q.stat)));
    // R11
    stat_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.stat[STW-1]);
endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wave_o, irq_o;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr_channel dut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wave_o(wave_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [6:0]  clkc;
        logic [6:0]  cntc;
        logic [15:0] ivl;
        logic [31:0] cyc;
        logic [15:0] exp;
    } vec_t;

    // clock setup, count control (restart set, waveform off), interval, cycles, expected count
    localparam vec_t VECS [7] = '{
        '{7'h00, 7'h30, 16'd0, 32'd20, 16'd19},     // R3 up free-running
        '{7'h00, 7'h32, 16'd5, 32'd30, 16'd5},      // R4 up interval
        '{7'h00, 7'h34, 16'd0, 32'd10, 16'hFFF7},   // R5 down free-running
        '{7'h00, 7'h36, 16'd7, 32'd27, 16'd6},      // R5 down interval
        '{7'h01, 7'h30, 16'd0, 32'd21, 16'd10},     // R6 divide by 2
        '{7'h05, 7'h30, 16'd0, 32'd50, 16'd6},      // R6 divide by 8
        '{7'h03, 7'h36, 16'd3, 32'd40, 16'd3}       // R6 divide by 4, down interval
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4'd1, v); chk("R1 count control", v, 16'h0021);
        rd(4'd0, v); chk("R1 clock setup", v, 16'h0000);
        rd(4'd2, v); chk("R1 counter", v, 16'h0000);
        chk("R1 wave", {15'd0, wave_o}, 16'd0);
        chk("R1 irq", {15'd0, irq_o}, 16'd0);

        // table of counting modes
        for (int i = 0; i < 7; i++) begin
            wr(4'd0, {9'd0, VECS[i].clkc});
            wr(4'd3, VECS[i].ivl);
            wr(4'd1, {9'd0, VECS[i].cntc});
            repeat (VECS[i].cyc) @(negedge clk);
            rd(4'd2, v);
            chk($sformatf("R3/R4/R5/R6 vector %0d", i), v, VECS[i].exp);
        end

        // R7 external rising then falling edges: 5 rises, 4 falls
        wr(4'd1, 16'h0021);
        ext_clk = 1'b0;
        wr(4'd0, 16'h0020);
        repeat (6) @(negedge clk);
        wr(4'd1, 16'h0030);
        repeat (4) @(negedge clk);
        for (int t = 0; t < 9; t++) begin
            ext_clk = ~ext_clk;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(4'd2, v); chk("R7 rising edges", v, 16'd5);
        ext_clk = 1'b0;
        repeat (6) @(negedge clk);
        wr(4'd0, 16'h0060);
        repeat (6) @(negedge clk);
        wr(4'd1, 16'h0030);
        repeat (4) @(negedge clk);
        for (int t = 0; t < 9; t++) begin
            ext_clk = ~ext_clk;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(4'd2, v); chk("R7 falling edges", v, 16'd4);

        // R13 waveform, interval 9, match 0 at 3
        wr(4'd1, 16'h0021);
        wr(4'd0, 16'h0000);
        wr(4'd3, 16'd9);
        wr(4'd4, 16'd3);
        rd(4'd7, v);
        wr(4'd1, 16'h0012);
        repeat (6) @(negedge clk);
        wr(4'd1, 16'h0003);
        rd(4'd2, v); chk("R13 count after run", v, 16'd6);
        chk("R13 wave after match, polarity 0", {15'd0, wave_o}, 16'd0);
        wr(4'd1, 16'h0012);
        repeat (12) @(negedge clk);
        wr(4'd1, 16'h0003);
        rd(4'd2, v); chk("R4 count after wrap", v, 16'd2);
        chk("R13 wave idle after wrap", {15'd0, wave_o}, 16'd1);
        rd(4'd7, v); chk("R4 interval flag", v, 16'h0001);
        wr(4'd1, 16'h0052);
        repeat (6) @(negedge clk);
        wr(4'd1, 16'h0043);
        chk("R13 wave polarity 1", {15'd0, wave_o}, 16'd1);
        wr(4'd1, 16'h0063);
        chk("R13 wave disabled", {15'd0, wave_o}, 16'd0);

        // R10 / R12 match flags and interrupt
        wr(4'd8, 16'h0004);
        wr(4'd5, 16'd4);
        wr(4'd1, 16'h0030);
        repeat (8) @(negedge clk);
        wr(4'd1, 16'h0021);
        chk("R12 irq low with no flag", {15'd0, irq_o}, 16'd0);
        rd(4'd7, v); chk("R10 no flag without match enable", v, 16'h0000);
        wr(4'd1, 16'h0038);
        repeat (8) @(negedge clk);
        wr(4'd1, 16'h0021);
        chk("R12 irq on enabled flag", {15'd0, irq_o}, 16'd1);
        rd(4'd7, v); chk("R10 match 0 and 1 flags", v, 16'h0006);
        chk("R11 irq after read clear", {15'd0, irq_o}, 16'd0);
        rd(4'd7, v); chk("R11 status cleared", v, 16'h0000);

        // R3 full wrap sets overflow flag
        wr(4'd1, 16'h0030);
        repeat (65540) @(negedge clk);
        wr(4'd1, 16'h0021);
        rd(4'd2, v); chk("R3 count past wrap", v, 16'd4);
        rd(4'd7, v); chk("R3 overflow flag", v, 16'h0010);
        repeat (5) @(negedge clk);
        rd(4'd2, v); chk("R8 disabled hold", v, 16'd4);
        wr(4'd2, 16'h1234);
        rd(4'd2, v); chk("R2 counter read-only", v, 16'd4);

        // R9 restart while disabled
        wr(4'd1, 16'h0031);
        rd(4'd1, v); chk("R9 restart bit pending", v, 16'h0031);
        rd(4'd1, v); chk("R9 restart bit self-clears", v, 16'h0021);
        rd(4'd2, v); chk("R9 counter zeroed", v, 16'd0);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule